// File: doc/BRIEF.md
# Converter Power Mode Sequencer

This block sets the power state of a data converter's digital side: Normal, Nap or Sleep. From power-on, a three-level mode strap picks the state. The strap arrives here already resolved into a 2-bit code. Later, a write to the power-down register can take over from the strap. The writes come from a serial control port that has already been decoded into address, data and write-enable. Once software has written a valid command, the strap has no further effect until reset.

Leaving Sleep has two timed windows. If chip select was high while the part slept, the register bank is asleep too. A falling chip select then opens a setup window, and register writes are dropped until that window closes. If chip select stayed low the whole time, there is no setup window. After a wake command, a power-up window must pass before the outputs are enabled again and ready is raised. When the sample clock was stopped during Nap, leaving Nap waits for a DLL-locked flag. Both windows are counted in clock cycles, derived from a clock-frequency parameter and delays given in microseconds.

Top module: `pwr_mode_seq`

## Requirements
- R1: Under strap control, strap code 00 selects Normal, 01 selects Sleep, and 10 or 11 select Nap. The state follows the strap one clock edge after it changes. Leaving Sleep toward Normal always passes through WakePowerUp.
- R2: After a valid command write is accepted, the strap input no longer affects the state until reset.
- R3: While in Sleep with chip select high, the register bank is off (regbank_ok_o low). A chip-select fall then enters WakeSetup (state 3) for SU_CYC cycles, and writes are ignored throughout. After that, Sleep resumes with regbank_ok_o high. If chip select rises during WakeSetup, the state returns to Sleep with the bank still off.
- R4: If chip select stays low throughout Sleep, regbank_ok_o stays high and a wake write is accepted at once, with no WakeSetup.
- R5: A write is a command only if addr_i equals PD_ADDR (default 25) and data bits above bit 3 are zero. The command field is data bits [3:1]: 001 requests Normal, 010 requests Nap and 100 requests Sleep. Bit 0 is ignored. Any other value leaves the state unchanged. An accepted command takes effect one edge after the write edge.
- R6: A wake request from Sleep enters WakePowerUp (state 4) for exactly PU_CYC cycles, then enters Normal.
- R7: The data, clock-out and over-range output enables are high only in Normal. They are low in Nap, Sleep, WakeSetup and WakePowerUp.
- R8: With clk_stop_i high, Nap moves to a requested Normal only on the edge after dll_lock_i is high. With clk_stop_i low, it moves on the next edge.
- R9: ready_o is high only in Normal with no window timer running.
- R10: Reset returns the block to Normal under strap control, with timers cleared and the register bank on. state_o encodes Normal=0, Nap=1, Sleep=2, WakeSetup=3, WakePowerUp=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (sample clock domain) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Resolved mode strap code |
| cs_ni | input | 1 | Serial port chip select, active low |
| reg_we_i | input | 1 | Decoded register write strobe |
| reg_addr_i | input | ADDR_W | Decoded register address |
| reg_wdata_i | input | DATA_W | Decoded register write data |
| clk_stop_i | input | 1 | Sample clock was stopped during Nap |
| dll_lock_i | input | 1 | DLL has regained lock |
| state_o | output | 3 | Current power state code |
| ready_o | output | 1 | Normal with no window running |
| regbank_ok_o | output | 1 | Register bank accepts writes |
| data_oe_o | output | 1 | Data output enable |
| clkout_oe_o | output | 1 | Clock-out output enable |
| ovr_oe_o | output | 1 | Over-range output enable |

## Verification
The assertions assume that strap_i, cs_ni and the write port are already synchronous to clk_i. They also assume register writes are presented only while chip select is low, as a decoded serial port would present them. The bench changes every input at the falling clock edge and issues writes only with cs_ni low. The single exception is chip select itself: it is raised during Sleep only with no write pending, to put the register bank to sleep. The assertions also treat clk_stop_i and dll_lock_i as static flags from the clock domain, so the bench changes them only between commands.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_NAP     = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_WAKE_SU = 3'd3,
    ST_WAKE_PU = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_NAP    = 2'd1,
    MD_SLEEP  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pms_strap_dec.sv
module pms_strap_dec
  import pms_pkg::*;
(
  input  logic [1:0] strap_i,
  output pwr_mode_e  mode_o
);
  always_comb begin
    unique casez (strap_i)
      2'b00:   mode_o = MD_NORMAL;
      2'b01:   mode_o = MD_SLEEP;   // floating strap
      default: mode_o = MD_NAP;     // strap tied high
    endcase
  end
endmodule

// File: rtl/pms_cmd_dec.sv
module pms_cmd_dec
  import pms_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PD_ADDR = 25
) (
  input  logic              we_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output pwr_mode_e         mode_o
);
  logic       sel;
  logic       code_ok;
  logic [2:0] code;
  logic       unused_lsb;

  assign unused_lsb = data_i[0];
  assign code       = data_i[3:1];
  assign sel        = we_i && en_i && (addr_i == ADDR_W'(PD_ADDR))
                      && (data_i[DATA_W-1:4] == '0);

  always_comb begin
    code_ok = 1'b1;
    mode_o  = MD_NORMAL;
    unique case (code)
      3'b001:  mode_o = MD_NORMAL;
      3'b010:  mode_o = MD_NAP;
      3'b100:  mode_o = MD_SLEEP;
      default: code_ok = 1'b0;
    endcase
  end

  assign hit_o = sel && code_ok;
endmodule

// File: rtl/pms_timer.sv
module pms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int SETUP_US = 150,
  parameter int PWRUP_US = 1000,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PD_ADDR  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  input  logic              cs_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              clk_stop_i,
  input  logic              dll_lock_i,
  output logic [2:0]        state_o,
  output logic              ready_o,
  output logic              regbank_ok_o,
  output logic              data_oe_o,
  output logic              clkout_oe_o,
  output logic              ovr_oe_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SU_CYC     = CYC_PER_US * SETUP_US;
  localparam int PU_CYC     = CYC_PER_US * PWRUP_US;
  localparam int MAX_CYC    = (SU_CYC > PU_CYC) ? SU_CYC : PU_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  pwr_state_e state_q, state_d;
  pwr_mode_e  strap_mode, cmd_mode, sw_mode_q, tgt;
  logic       sw_own_q, cmd_hit;
  logic       regs_on_q, regs_on_d;
  logic       cs_q, cs_fall;
  logic       su_load, su_clr, su_done;
  logic       pu_load, pu_clr, pu_done;

  pms_strap_dec i_strap (
    .strap_i (strap_i),
    .mode_o  (strap_mode)
  );

  pms_cmd_dec #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PD_ADDR (PD_ADDR)
  ) i_cmd (
    .we_i   (reg_we_i),
    .en_i   (regs_on_q),
    .addr_i (reg_addr_i),
    .data_i (reg_wdata_i),
    .hit_o  (cmd_hit),
    .mode_o (cmd_mode)
  );

  pms_timer #(.CNT_W(CNT_W)) i_su_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (su_load),
    .clr_i      (su_clr),
    .load_val_i (CNT_W'(SU_CYC - 1)),
    .done_o     (su_done)
  );

  pms_timer #(.CNT_W(CNT_W)) i_pu_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pu_load),
    .clr_i      (pu_clr),
    .load_val_i (CNT_W'(PU_CYC - 1)),
    .done_o     (pu_done)
  );

  // software ownership: first valid command wins over the strap for good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_own_q  <= 1'b0;
      sw_mode_q <= MD_NORMAL;
    end else if (cmd_hit) begin
      sw_own_q  <= 1'b1;
      sw_mode_q <= cmd_mode;
    end
  end

  assign tgt     = sw_own_q ? sw_mode_q : strap_mode;
  assign cs_fall = cs_q && !cs_ni;

  always_comb begin
    state_d   = state_q;
    regs_on_d = regs_on_q;
    su_load   = 1'b0;
    su_clr    = 1'b0;
    pu_load   = 1'b0;
    pu_clr    = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (tgt == MD_NAP)        state_d = ST_NAP;
        else if (tgt == MD_SLEEP) state_d = ST_SLEEP;
      end
      ST_NAP: begin
        if (tgt == MD_SLEEP) state_d = ST_SLEEP;
        else if (tgt == MD_NORMAL && (!clk_stop_i || dll_lock_i))
          state_d = ST_NORMAL;
      end
      ST_SLEEP: begin
        if (tgt == MD_NORMAL) begin
          state_d = ST_WAKE_PU;
          pu_load = 1'b1;
        end else if (tgt == MD_NAP) begin
          state_d = ST_NAP;
        end else if (cs_fall && !regs_on_q) begin
          state_d = ST_WAKE_SU;
          su_load = 1'b1;
        end
      end
      ST_WAKE_SU: begin
        if (cs_ni) begin
          state_d = ST_SLEEP;
          su_clr  = 1'b1;
        end else if (su_done) begin
          state_d   = ST_SLEEP;
          regs_on_d = 1'b1;
        end
      end
      ST_WAKE_PU: begin
        if (tgt == MD_SLEEP) begin
          state_d = ST_SLEEP;
          pu_clr  = 1'b1;
        end else if (tgt == MD_NAP) begin
          state_d = ST_NAP;
          pu_clr  = 1'b1;
        end else if (pu_done) begin
          state_d = ST_NORMAL;
        end
      end
      default: state_d = ST_NORMAL;
    endcase
    // register bank power follows chip select only while asleep
    if (state_q == ST_SLEEP && cs_ni)
      regs_on_d = 1'b0;
    else if (state_q != ST_SLEEP && state_q != ST_WAKE_SU)
      regs_on_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_NORMAL;
      regs_on_q <= 1'b1;
      cs_q      <= 1'b1;
    end else begin
      state_q   <= state_d;
      regs_on_q <= regs_on_d;
      cs_q      <= cs_ni;
    end
  end

  assign state_o      = state_q;
  assign ready_o      = (state_q == ST_NORMAL) && su_done && pu_done;
  assign regbank_ok_o = regs_on_q;
  assign data_oe_o    = (state_q == ST_NORMAL);
  assign clkout_oe_o  = (state_q == ST_NORMAL);
  assign ovr_oe_o     = (state_q == ST_NORMAL);
endmodule

// File: rtl/pms_checks.sv
module pms_checks
  import pms_pkg::*;
#(
  parameter int SU_CYC = 4,
  parameter int PU_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_o,
  input logic       regbank_ok_o,
  input logic       data_oe_o,
  input logic       ready_o,
  input logic       clk_stop_i,
  input logic       dll_lock_i
);
  localparam int CW = $clog2(SU_CYC + PU_CYC + 2) + 1;

  logic [CW-1:0] su_cnt, pu_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      su_cnt <= '0;
      pu_cnt <= '0;
    end else begin
      su_cnt <= (state_o == 3'(ST_WAKE_SU)) ? su_cnt + 1'b1 : '0;
      pu_cnt <= (state_o == 3'(ST_WAKE_PU)) ? pu_cnt + 1'b1 : '0;
    end
  end

  // R10 state code stays within the defined set
  a_r10_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  // R3 setup window length before the bank comes back
  a_r3_setup_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(regbank_ok_o) && $past(state_o) == 3'(ST_WAKE_SU)) |-> su_cnt == CW'(SU_CYC));

  // R6 power-up window length
  a_r6_pwrup_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(ST_NORMAL) && $past(state_o) == 3'(ST_WAKE_PU)) |-> pu_cnt == CW'(PU_CYC));

  // R7 outputs re-enable only out of Nap or the power-up window
  a_r7_oe_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> ($past(state_o) == 3'(ST_NAP) || $past(state_o) == 3'(ST_WAKE_PU)));

  // R8 no Nap exit without lock when the clock was stopped
  a_r8_nap_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(ST_NAP) && clk_stop_i && !dll_lock_i) |=> state_o != 3'(ST_NORMAL));

  // R9 ready implies outputs are driven
  a_r9_ready_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> data_oe_o);
endmodule

bind pwr_mode_seq pms_checks #(
  .SU_CYC (SU_CYC),
  .PU_CYC (PU_CYC)
) i_pms_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_o      (state_o),
  .regbank_ok_o (regbank_ok_o),
  .data_oe_o    (data_oe_o),
  .ready_o      (ready_o),
  .clk_stop_i   (clk_stop_i),
  .dll_lock_i   (dll_lock_i)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SU         = 5;
  localparam int PU         = 12;
  localparam int NV         = 7;

  // {strap[1:0], expected state[2:0]}
  localparam logic [4:0] VEC [NV] = '{
    5'b00_000, 5'b10_001, 5'b00_000, 5'b01_010,
    5'b11_001, 5'b01_010, 5'b00_100
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       cs_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'd0;
  logic [7:0] wdata = 8'd0;
  logic       clk_stop = 1'b0;
  logic       dll_lock = 1'b0;
  logic [2:0] state;
  logic       ready, rb_ok, d_oe, c_oe, o_oe;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(
    .CLK_HZ(1_000_000), .SETUP_US(SU), .PWRUP_US(PU),
    .ADDR_W(8), .DATA_W(8), .PD_ADDR(25)
  ) i_pwr_mode_seq (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .cs_ni(cs_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .clk_stop_i(clk_stop), .dll_lock_i(dll_lock),
    .state_o(state), .ready_o(ready), .regbank_ok_o(rb_ok),
    .data_oe_o(d_oe), .clkout_oe_o(c_oe), .ovr_oe_o(o_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic chk_oe(input string req, input int exp);
    chk(req, int'({d_oe, c_oe, o_oe}), exp ? 7 : 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100_000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100_000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R10 reset values
    chk("R10 state", state, 0);
    chk("R10 ready", ready, 1);
    chk("R10 regbank", rb_ok, 1);
    chk_oe("R10 oe", 1);
    rst_ni = 1'b1;
    tick(1);

    // R1 strap walk
    for (int i = 0; i < NV; i++) begin
      strap = VEC[i][4:3];
      tick(1);
      chk("R1 strap", state, int'(VEC[i][2:0]));
      chk_oe("R7 oe", VEC[i][2:0] == 3'd0);
    end
    tick(PU - 1);
    chk("R6 still powering", state, 4);
    chk("R9 not ready", ready, 0);
    tick(1);
    chk("R6 normal", state, 0);
    chk("R9 ready", ready, 1);

    // R2 software takes over
    wr(8'd25, 8'b1000); tick(1);
    chk("R5 sleep cmd", state, 2);
    strap = 2'b10; tick(3);
    chk("R2 strap ignored", state, 2);

    // R3 setup window
    cs_n = 1'b1; tick(2);
    chk("R3 bank off", rb_ok, 0);
    cs_n = 1'b0; tick(1);
    chk("R3 enter setup", state, 3);
    wr(8'd25, 8'b0010); tick(1);
    chk("R3 write ignored", state, 3);
    tick(SU - 3);
    chk("R3 still setup", state, 3);
    chk("R3 bank still off", rb_ok, 0);
    tick(1);
    chk("R3 back to sleep", state, 2);
    chk("R3 bank on", rb_ok, 1);
    wr(8'd25, 8'b0011); tick(1);
    chk("R5 lsb dont care", state, 4);
    tick(PU);
    chk("R6 normal again", state, 0);

    // R5 rejected writes
    wr(8'd25, 8'b1110); tick(1);
    chk("R5 bad code", state, 0);
    wr(8'd25, 8'b0000); tick(1);
    chk("R5 zero code", state, 0);
    wr(8'd24, 8'b1000); tick(1);
    chk("R5 wrong addr", state, 0);
    wr(8'd25, 8'b0001_1000); tick(1);
    chk("R5 upper bits", state, 0);

    // R4 chip select held low through sleep
    wr(8'd25, 8'b1000); tick(3);
    chk("R4 bank stays on", rb_ok, 1);
    wr(8'd25, 8'b0010); tick(1);
    chk("R4 immediate wake", state, 4);
    tick(PU);
    chk("R4 normal", state, 0);

    // R8 nap exit with stopped clock
    clk_stop = 1'b1;
    wr(8'd25, 8'b0100); tick(1);
    chk("R8 nap", state, 1);
    chk_oe("R7 nap oe", 0);
    wr(8'd25, 8'b0010); tick(4);
    chk("R8 waits lock", state, 1);
    dll_lock = 1'b1; tick(1);
    chk("R8 locked exit", state, 0);
    clk_stop = 1'b0; dll_lock = 1'b0;
    wr(8'd25, 8'b0100); tick(1);
    wr(8'd25, 8'b0010); tick(1);
    chk("R8 running clock exit", state, 0);

    // R10 reset restores strap control (strap is 10 = Nap)
    wr(8'd25, 8'b1000); tick(1);
    chk("R10 pre sleep", state, 2);
    rst_ni = 1'b0; tick(1);
    chk("R10 reset state", state, 0);
    rst_ni = 1'b1; tick(1);
    chk("R10 strap nap", state, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule